// File: doc/BRIEF.md
# Paged Register Window Controller

This block sits behind the CPU register port of a bus-interface device that can present one of two controller register maps. A mode strap, captured right after hardware reset, picks either a flat map or a paged map. In the flat map, one register address (the window slot) is an ordinary read/write register. In the paged map, that slot has no storage of its own. A write to it goes nowhere until a page-in command reaches the command register.

The four page-in codes each point the window slot at one of four write-only registers. The choice persists until the clear-page code or a reset. A newer page-in replaces the older one. While any page is in, two read-only status registers become visible: a serial-poll status byte and a second interrupt-status byte. Their values arrive on input ports from the surrounding logic. When no page is in, both read as zero.

In the paged map, a swap input moves the register addresses by inverting address bits 3 and 2. Read data is registered and appears one cycle after the read strobe.

Top module: `paged_window_ctrl`

## Requirements
- R1: After reset, page_active_o is 0, every paged register and the flat slot register are 0, and rdata_o is 0.
- R2: The mode strap is captured on the first rising clock edge after rst_ni goes high: strap 1 selects the flat map, strap 0 the paged map. Strap changes after that edge have no effect until the next reset.
- R3: In the paged map with no page active, a write to the window slot changes no paged register.
- R4: In the paged map, writing 0x50+n (n = 0..3) to the command register activates page n. page_active_o goes to 1, and later window-slot writes load paged register n only (bits [8n+7:8n] of page_regs_o).
- R5: A page-in written while another page is active replaces it. Later slot writes reach only the newly selected register.
- R6: Writing 0x54 to the command register deactivates paging. page_active_o goes to 0, slot writes are again ignored, and the two status registers read as 0.
- R7: In the paged map, any command code other than 0x50..0x54 leaves the page state unchanged.
- R8: In the paged map with a page active, a read of the serial-poll address returns spoll_stat_i and a read of the interrupt-status address returns isr2_stat_i. All other reads return 0, and so do these two reads when no page is active. Read data is valid in the cycle after the read strobe.
- R9: Paged map addresses with swap_i low are window slot 0x04, command 0x06, serial-poll 0x0C and interrupt-status 0x0E. With swap_i high every address has bits 3:2 inverted, giving 0x08, 0x0A, 0x00 and 0x02.
- R10: In the flat map, 0x04 is a plain read/write register (flat_reg_o) and the command register sits at 0x0A. Page commands have no effect, page_active_o stays 0, swap_i is ignored, and the status addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_strap_i | input | 1 | Map select captured after reset (1 flat, 0 paged) |
| swap_i | input | 1 | Address swap in the paged map |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 5 | Register address |
| wdata_i | input | 8 | Write data |
| spoll_stat_i | input | 8 | Serial-poll status value shown while paged |
| isr2_stat_i | input | 8 | Interrupt-status value shown while paged |
| rdata_o | output | 8 | Registered read data |
| page_active_o | output | 1 | Any page active |
| page_regs_o | output | 32 | Four paged write-only registers, register n at bits [8n+7:8n] |
| flat_reg_o | output | 8 | Window slot register in the flat map |

## Verification
The hardest case is a command code that lands while a page is already active. Codes outside the page range must leave the selection alone, and a new page-in must replace the old one. Neither shows on page_active_o, so the selection is visible only when a later slot write lands in a particular register.

The bench handles this by first selecting a known page. It then writes each of the 256 command codes in turn and follows every code with a distinctive slot write. The target register is identified by data that changes with each code. The whole sweep runs once with the swap input low and once with it high.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  localparam logic [7:0] CMD_PAGE_BASE = 8'h50;
  localparam logic [4:0] ADR_SLOT      = 5'h04;
  localparam logic [4:0] ADR_CMD_PAGED = 5'h06;
  localparam logic [4:0] ADR_CMD_FLAT  = 5'h0A;
  localparam logic [4:0] ADR_SPOLL     = 5'h0C;
  localparam logic [4:0] ADR_ISR2      = 5'h0E;
  localparam logic [4:0] SWAP_MASK     = 5'h0C;

  typedef enum logic {MAP_PAGED = 1'b0, MAP_FLAT = 1'b1} map_e;

  typedef struct packed {
    logic cmd_wr;
    logic slot_wr;
    logic slot_rd;
    logic spoll_rd;
    logic isr2_rd;
  } dec_t;
endpackage

// File: rtl/pgw_mode_latch.sv
module pgw_mode_latch
  import pgw_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strap_i,
  output map_e map_o
);
  logic armed_q;
  map_e map_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      map_q   <= MAP_PAGED;
    end else if (!armed_q) begin
      armed_q <= 1'b1;
      map_q   <= map_e'(strap_i);
    end
  end

  assign map_o = map_q;

  assert_strap_frozen_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |=> $stable(map_q));
endmodule

// File: rtl/pgw_addr_dec.sv
module pgw_addr_dec
  import pgw_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  map_e          map_i,
  input  logic          swap_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  output dec_t          dec_o
);
  logic [AW-1:0] eff;
  logic          flat;

  assign flat = (map_i == MAP_FLAT);
  // swap only remaps the paged map
  assign eff  = (!flat && swap_i) ? (addr_i ^ AW'(SWAP_MASK)) : addr_i;

  always_comb begin
    dec_o          = '0;
    dec_o.cmd_wr   = wr_en_i && (eff == (flat ? AW'(ADR_CMD_FLAT) : AW'(ADR_CMD_PAGED)));
    dec_o.slot_wr  = wr_en_i && (eff == AW'(ADR_SLOT));
    dec_o.slot_rd  = rd_en_i && flat && (eff == AW'(ADR_SLOT));
    dec_o.spoll_rd = rd_en_i && !flat && (eff == AW'(ADR_SPOLL));
    dec_o.isr2_rd  = rd_en_i && !flat && (eff == AW'(ADR_ISR2));
  end

  assert_one_target_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dec_o.cmd_wr, dec_o.slot_wr, dec_o.slot_rd, dec_o.spoll_rd, dec_o.isr2_rd}));
endmodule

// File: rtl/pgw_page_ctl.sv
module pgw_page_ctl
  import pgw_pkg::*;
#(
  parameter int DW    = 8,
  parameter int NPAGE = 4,
  localparam int PW   = (NPAGE > 1) ? $clog2(NPAGE) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  map_e          map_i,
  input  logic          cmd_wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          page_on_o,
  output logic [PW-1:0] page_sel_o
);
  logic [DW-1:0] off;
  logic          is_pagein, is_clear, cmd_ok;
  logic          on_q;
  logic [PW-1:0] sel_q;

  assign off       = wdata_i - DW'(CMD_PAGE_BASE);
  assign is_pagein = (off < DW'(NPAGE));
  assign is_clear  = (off == DW'(NPAGE));
  assign cmd_ok    = cmd_wr_i && (map_i == MAP_PAGED);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_q  <= 1'b0;
      sel_q <= '0;
    end else if (cmd_ok) begin
      if (is_pagein) begin
        on_q  <= 1'b1;
        sel_q <= PW'(off);
      end else if (is_clear) begin
        on_q  <= 1'b0;
      end
    end
  end

  assign page_on_o  = on_q;
  assign page_sel_o = sel_q;

  assert_clear_pages_out_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_ok && wdata_i == DW'(CMD_PAGE_BASE) + DW'(NPAGE)) |=> !page_on_o);
  assert_other_cmd_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_ok && (wdata_i < DW'(CMD_PAGE_BASE) || wdata_i > DW'(CMD_PAGE_BASE) + DW'(NPAGE)))
      |=> ($stable(page_on_o) && $stable(page_sel_o)));
  assert_flat_no_page_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (map_i == MAP_FLAT && !page_on_o) |=> !page_on_o);
endmodule

// File: rtl/pgw_reg_bank.sv
module pgw_reg_bank
  import pgw_pkg::*;
#(
  parameter int DW    = 8,
  parameter int NPAGE = 4,
  localparam int PW   = (NPAGE > 1) ? $clog2(NPAGE) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  map_e                map_i,
  input  logic                slot_wr_i,
  input  logic                page_on_i,
  input  logic [PW-1:0]       page_sel_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [NPAGE*DW-1:0] page_regs_o,
  output logic [DW-1:0]       flat_reg_o
);
  logic [NPAGE-1:0] we;
  logic [DW-1:0]    flat_q;

  for (genvar g = 0; g < NPAGE; g++) begin : g_page
    logic [DW-1:0] r_q;
    assign we[g] = slot_wr_i && (map_i == MAP_PAGED) && page_on_i && (page_sel_i == PW'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    r_q <= '0;
      else if (we[g]) r_q <= wdata_i;
    end
    assign page_regs_o[g*DW +: DW] = r_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              flat_q <= '0;
    else if (slot_wr_i && map_i == MAP_FLAT)  flat_q <= wdata_i;
  end
  assign flat_reg_o = flat_q;

  assert_unpaged_slot_dead_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!page_on_i) |=> $stable(page_regs_o));
  assert_single_target_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(we));
endmodule

// File: rtl/paged_window_ctrl.sv
module paged_window_ctrl
  import pgw_pkg::*;
#(
  parameter int AW    = 5,
  parameter int DW    = 8,
  parameter int NPAGE = 4,
  localparam int PW   = (NPAGE > 1) ? $clog2(NPAGE) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                mode_strap_i,
  input  logic                swap_i,
  input  logic                wr_en_i,
  input  logic                rd_en_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [DW-1:0]       wdata_i,
  input  logic [DW-1:0]       spoll_stat_i,
  input  logic [DW-1:0]       isr2_stat_i,
  output logic [DW-1:0]       rdata_o,
  output logic                page_active_o,
  output logic [NPAGE*DW-1:0] page_regs_o,
  output logic [DW-1:0]       flat_reg_o
);
  map_e          map;
  dec_t          dec;
  logic          page_on;
  logic [PW-1:0] page_sel;
  logic [DW-1:0] rd_val, rdata_q;

  pgw_mode_latch u_mode (
    .clk_i, .rst_ni, .strap_i(mode_strap_i), .map_o(map)
  );

  pgw_addr_dec #(.AW(AW)) u_dec (
    .clk_i, .rst_ni, .map_i(map), .swap_i, .wr_en_i, .rd_en_i, .addr_i, .dec_o(dec)
  );

  pgw_page_ctl #(.DW(DW), .NPAGE(NPAGE)) u_page (
    .clk_i, .rst_ni, .map_i(map), .cmd_wr_i(dec.cmd_wr), .wdata_i,
    .page_on_o(page_on), .page_sel_o(page_sel)
  );

  pgw_reg_bank #(.DW(DW), .NPAGE(NPAGE)) u_bank (
    .clk_i, .rst_ni, .map_i(map), .slot_wr_i(dec.slot_wr), .page_on_i(page_on),
    .page_sel_i(page_sel), .wdata_i, .page_regs_o, .flat_reg_o
  );

  always_comb begin
    rd_val = '0;
    if (dec.slot_rd)                 rd_val = flat_reg_o;
    else if (dec.spoll_rd && page_on) rd_val = spoll_stat_i;
    else if (dec.isr2_rd && page_on)  rd_val = isr2_stat_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rd_val;
  end

  assign rdata_o       = rdata_q;
  assign page_active_o = page_on;

  assert_hidden_reads_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!page_on && map == MAP_PAGED) |=> (rdata_o == '0));
  assert_idle_read_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_en_i) |=> (rdata_o == '0));
endmodule

// File: tb/paged_window_ctrl_bench.sv
module paged_window_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap = 1'b0, swap = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [4:0]  addr = '0;
  logic [7:0]  wdata = '0, spoll = 8'h3C, isr2 = 8'hC9;
  logic [7:0]  rdata, flat_reg;
  logic        pact;
  logic [31:0] pregs;

  int errors = 0, checks = 0;
  bit done = 0;

  // bench model
  bit         m_flat, m_on;
  int         m_sel;
  logic [7:0] m_regs [4];
  logic [7:0] m_flatreg;

  always #2 clk = ~clk;

  paged_window_ctrl u_paged_window_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .mode_strap_i(strap), .swap_i(swap),
    .wr_en_i(wr), .rd_en_i(rd), .addr_i(addr), .wdata_i(wdata),
    .spoll_stat_i(spoll), .isr2_stat_i(isr2), .rdata_o(rdata),
    .page_active_o(pact), .page_regs_o(pregs), .flat_reg_o(flat_reg)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] logical(input logic [4:0] a);
    return (!m_flat && swap) ? (a ^ 5'h0C) : a;
  endfunction

  task automatic check_state(input string req);
    logic [31:0] e;
    e = {m_regs[3], m_regs[2], m_regs[1], m_regs[0]};
    chk(pact == m_on, req, {31'd0, pact}, {31'd0, m_on});
    chk(pregs == e, req, pregs, e);
    chk(flat_reg == m_flatreg, req, {24'd0, flat_reg}, {24'd0, m_flatreg});
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [7:0] d);
    logic [4:0] l;
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
    l = logical(a);
    if (m_flat) begin
      if (l == 5'h04) m_flatreg = d;
    end else begin
      if (l == 5'h06) begin
        if (d >= 8'h50 && d <= 8'h53) begin m_on = 1; m_sel = int'(d - 8'h50); end
        else if (d == 8'h54) m_on = 0;
      end else if (l == 5'h04 && m_on) m_regs[m_sel] = d;
    end
  endtask

  task automatic bus_rd(input logic [4:0] a, input string req);
    logic [4:0] l;
    logic [7:0] e;
    l = logical(a);
    e = 8'h00;
    if (m_flat) begin
      if (l == 5'h04) e = m_flatreg;
    end else if (m_on) begin
      if (l == 5'h0C) e = spoll;
      else if (l == 5'h0E) e = isr2;
    end
    @(negedge clk);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
    chk(rdata == e, req, {24'd0, rdata}, {24'd0, e});
  endtask

  task automatic do_reset(input bit s);
    strap = s;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_flat = s; m_on = 0; m_sel = 0; m_flatreg = '0;
    for (int i = 0; i < 4; i++) m_regs[i] = '0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    do_reset(1'b0);
    check_state("R1");
    chk(rdata == 8'h00, "R1", {24'd0, rdata}, 32'd0);

    // R3: slot write with no page, both swap settings
    for (int s = 0; s < 2; s++) begin
      swap = s[0];
      for (int a = 0; a < 32; a++) begin
        bus_wr(a[4:0], 8'hE0 + 8'(a));
        check_state("R3_R9");
      end
      for (int a = 0; a < 32; a++) bus_rd(a[4:0], "R8_hidden");
      bus_wr(5'h06 ^ (swap ? 5'h0C : 5'h00), 8'h54);
    end

    // R2: strap change after capture is ignored
    strap = 1'b1;
    swap = 1'b0;

    // R4/R5/R7: every command code, from a known active page
    for (int s = 0; s < 2; s++) begin
      swap = s[0];
      for (int c = 0; c < 256; c++) begin
        bus_wr(logical(5'h06), 8'h51);
        bus_wr(logical(5'h06), 8'(c));
        bus_wr(logical(5'h04), 8'(c) ^ 8'hA5);
        check_state((c >= 8'h50 && c <= 8'h54) ? "R4_R5_R6" : "R7");
        if (c[4:0] == 5'd0) begin
          spoll = 8'(c) ^ 8'h0F; isr2 = 8'(c) ^ 8'hF0;
          for (int a = 0; a < 32; a++) bus_rd(a[4:0], "R8_R9");
        end
      end
    end
    chk(!m_flat, "R2", {31'd0, m_flat}, 32'd0);

    // R6: clear then slot writes ignored, reads zero
    swap = 1'b0;
    bus_wr(5'h06, 8'h53);
    bus_wr(5'h04, 8'h77);
    check_state("R4");
    bus_wr(5'h06, 8'h54);
    bus_wr(5'h04, 8'h99);
    check_state("R6");
    bus_rd(5'h0C, "R6");
    bus_rd(5'h0E, "R6");

    // R10: flat map
    do_reset(1'b1);
    check_state("R1");
    for (int s = 0; s < 2; s++) begin
      swap = s[0];
      for (int c = 8'h4F; c <= 8'h55; c++) begin
        bus_wr(5'h0A, 8'(c));
        bus_wr(5'h06, 8'(c));
        bus_wr(5'h04, 8'(c) + 8'h10);
        check_state("R10");
      end
      for (int a = 0; a < 32; a++) bus_rd(a[4:0], "R10");
    end
    strap = 1'b0;
    bus_wr(5'h06, 8'h50);
    check_state("R2_R10");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule